// File: doc/BRIEF.md
# Four-Phase Packed-BCD Adjust and Decrement Unit

This block is the 8-bit arithmetic slice of a small accumulator machine. It executes one of two instructions per instruction cycle: a decimal adjust, which corrects the working register after a binary addition of two packed-BCD bytes, and a decrement, which subtracts one from a file-register operand and sends the result either to the working register or back to the file register.

Every instruction cycle has four clock phases: decode, operand read, execute and write-back. The phase counter runs freely and is visible on a port, so the surrounding pipeline can present a new instruction at the start of each decode phase and hold it for the whole cycle. The working register, the file write-back value and the five status flags are held in the block. The instruction fetch, the address generation and the register file itself belong to other blocks.

Top module: `bcdu_core`

## Requirements
- R1: `phase_o` counts 0 (decode), 1 (read), 2 (execute), 3 (write) and then returns to 0. It advances by one on every clock edge while `rst_n` is high, and it holds at 0 while `rst_n` is low.
- R2: A low `rst_n` at a clock edge clears `w_out`, `file_out`, `file_we` and all five flags, and returns the phase to 0. This applies in any phase, including in the middle of an instruction.
- R3: `op_sel` (0 = decimal adjust, 1 = decrement) and `dest_sel` are captured at the end of phase 0. `file_in`, `c_in` and `dc_in` are captured at the end of phase 1. `w_out` and the flags take their new values at the end of phase 3.
- R4: Decimal adjust, low nibble: when W[3:0] is greater than 9, or when `dc_in` is 1, the unit adds 6 to the low nibble. The low nibble of the result is that sum truncated to 4 bits, and the carry out of that sum is passed to the high nibble. Otherwise the low nibble passes through unchanged and the carry is 0.
- R5: Decimal adjust, high nibble: take h = W[7:4] + carry. When h is greater than 9, or when `c_in` is 1, the new high nibble is h + 6 truncated to 4 bits. Otherwise it is h truncated to 4 bits.
- R6: Decimal adjust sets C to 1 when the high-nibble correction overflows 4 bits or when `c_in` is 1, and clears it otherwise. It leaves DC, N, OV and Z unchanged, never raises `file_we`, and ignores `file_in` and `dest_sel`.
- R7: Decrement computes `file_in` − 1 (mod 256). With `dest_sel` = 0 the result goes to W. With `dest_sel` = 1 the result appears on `file_out` with `file_we` high during phase 3 only, and W is unchanged.
- R8: Decrement sets C to 1 unless the operand is 00h, and sets DC to 1 unless the operand's low nibble is 0.
- R9: Decrement sets N to bit 7 of the result and Z to 1 when the result is 00h. It sets OV only when the operand is 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 1 | Operation: 0 decimal adjust, 1 decrement |
| dest_sel | input | 1 | Decrement destination: 0 W, 1 file |
| file_in | input | 8 | File-register operand |
| c_in | input | 1 | Incoming carry flag |
| dc_in | input | 1 | Incoming digit-carry flag |
| phase_o | output | 2 | Current phase 0..3 |
| w_out | output | 8 | Working register |
| file_out | output | 8 | File write-back value |
| file_we | output | 1 | File write strobe, phase 3 only |
| c_o | output | 1 | Carry / no-borrow flag |
| dc_o | output | 1 | Digit-carry / no-nibble-borrow flag |
| n_o | output | 1 | Negative flag |
| ov_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |

## Verification
The adjust is tried with four kinds of input. In the first, only the high nibble is out of range (A5h), which shows the high-nibble correction and the carry out. In the second, both nibbles are out of range (CEh), so the low-nibble carry also feeds the high-nibble sum. In the third, both nibbles are already valid and the incoming flags are 0 (99h), which must pass through unchanged. In the fourth, the incoming DC or C flag alone forces a correction on nibbles that are in range. A chained case (9Ah going to 00h with C set) shows that the low-nibble carry alone can push the high nibble over 9. The decrement is tried with 01h, 80h, 00h and ordinary operands, to separate zero detection, the overflow case and full and nibble borrows. Both destinations are used. A reset in the middle of an instruction is also applied.

// File: rtl/bcdu_pkg.sv
// Shared widths, phase encoding and flag layout for the BCD-adjust/decrement unit.
// Assumes a byte-wide datapath made of two nibbles.
package bcdu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int PH_N   = 4;
    localparam int PH_W   = $clog2(PH_N);
    localparam int BCD_MAX = 9;
    localparam int BCD_FIX = 6;

    typedef enum logic [PH_W-1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    localparam logic OP_ADJ = 1'b0;
    localparam logic OP_DEC = 1'b1;

    typedef struct packed {
        logic c;
        logic dc;
        logic n;
        logic ov;
        logic z;
    } flags_t;
endpackage

// File: rtl/bcdu_phase_seq.sv
// Free-running four-phase sequencer: decode, read, execute, write.
// Assumes the reset is synchronous and active low; the phase restarts at decode.
module bcdu_phase_seq
    import bcdu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);
    logic [PH_W-1:0] cnt_q;

    // Advance the phase counter once per clock edge, wrapping after the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + PH_W'(1);
    end

    assign phase = phase_e'(cnt_q);

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_DECODE));

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> (cnt_q == $past(cnt_q) + PH_W'(1)));
endmodule

// File: rtl/bcdu_adjust.sv
// Combinational packed-BCD correction of a byte.
// The low nibble is corrected first, and its carry enters the high-nibble test and sum.
// Assumes the incoming C and DC come from the addition that produced the byte.
module bcdu_adjust
    import bcdu_pkg::*;
(
    input  logic [DATA_W-1:0] w_val,
    input  logic              c_in,
    input  logic              dc_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);
    logic [NIB_W:0] lo_sum;
    logic [NIB_W:0] hi_base;
    logic [NIB_W:0] hi_sum;
    logic           lo_cy;

    // Low nibble: add six when it is out of range or the digit carry is set.
    always_comb begin
        if ((w_val[NIB_W-1:0] > NIB_W'(BCD_MAX)) || dc_in)
            lo_sum = {1'b0, w_val[NIB_W-1:0]} + (NIB_W+1)'(BCD_FIX);
        else
            lo_sum = {1'b0, w_val[NIB_W-1:0]};
        lo_cy = lo_sum[NIB_W];
    end

    // High nibble: fold in the low carry, then add six when out of range or carry set.
    always_comb begin
        hi_base = {1'b0, w_val[DATA_W-1:NIB_W]} + (NIB_W+1)'(lo_cy);
        if ((hi_base > (NIB_W+1)'(BCD_MAX)) || c_in)
            hi_sum = hi_base + (NIB_W+1)'(BCD_FIX);
        else
            hi_sum = hi_base;
    end

    assign res   = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
    assign c_out = hi_sum[NIB_W] | c_in;
endmodule

// File: rtl/bcdu_decr.sv
// Combinational byte decrement with borrow-style status flags.
// C and DC read as "no borrow"; OV flags the only signed wrap, min-negative to max-positive.
module bcdu_decr
    import bcdu_pkg::*;
(
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res,
    output flags_t            fl
);
    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    // Form the result and all five flags from the operand.
    always_comb begin
        res   = opnd - DATA_W'(1);
        fl.c  = (opnd != '0);
        fl.dc = (opnd[NIB_W-1:0] != '0);
        fl.n  = res[DATA_W-1];
        fl.ov = (opnd == MIN_NEG);
        fl.z  = (res == '0);
    end
endmodule

// File: rtl/bcdu_core.sv
// Four-phase execution unit: decimal adjust of W, or decrement of a file operand.
// Decode latches the opcode, read latches the operands, execute registers the result
// and the next flags, and write commits W and the flags and strobes the file write.
// Assumes the caller holds its inputs steady from decode through read.
module bcdu_core
    import bcdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_sel,
    input  logic              dest_sel,
    input  logic [DATA_W-1:0] file_in,
    input  logic              c_in,
    input  logic              dc_in,
    output logic [PH_W-1:0]   phase_o,
    output logic [DATA_W-1:0] w_out,
    output logic [DATA_W-1:0] file_out,
    output logic              file_we,
    output logic              c_o,
    output logic              dc_o,
    output logic              n_o,
    output logic              ov_o,
    output logic              z_o
);
    phase_e            phase;
    logic              op_q, dest_q;
    logic [DATA_W-1:0] opnd_q, wsrc_q, w_q, res_q;
    logic              cin_q, dcin_q;
    flags_t            flags_q, nfl_q;
    logic [DATA_W-1:0] adj_res, dec_res;
    logic              adj_c;
    flags_t            dec_fl;

    bcdu_phase_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    bcdu_adjust u_adj (
        .w_val (wsrc_q),
        .c_in  (cin_q),
        .dc_in (dcin_q),
        .res   (adj_res),
        .c_out (adj_c)
    );

    bcdu_decr u_dec (
        .opnd (opnd_q),
        .res  (dec_res),
        .fl   (dec_fl)
    );

    // Decode phase: capture the operation and the destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_ADJ;
            dest_q <= 1'b0;
        end else if (phase == PH_DECODE) begin
            op_q   <= op_sel;
            dest_q <= dest_sel;
        end
    end

    // Read phase: capture the file operand, a snapshot of W and the incoming flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            wsrc_q <= '0;
            cin_q  <= 1'b0;
            dcin_q <= 1'b0;
        end else if (phase == PH_READ) begin
            opnd_q <= file_in;
            wsrc_q <= w_q;
            cin_q  <= c_in;
            dcin_q <= dc_in;
        end
    end

    // Execute phase: register the selected result and the next flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            nfl_q <= '0;
        end else if (phase == PH_EXEC) begin
            if (op_q == OP_DEC) begin
                res_q <= dec_res;
                nfl_q <= dec_fl;
            end else begin
                res_q <= adj_res;
                nfl_q <= '{c: adj_c, dc: flags_q.dc, n: flags_q.n,
                           ov: flags_q.ov, z: flags_q.z};
            end
        end
    end

    // Write phase: commit W (adjust, or decrement to W) and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q     <= '0;
            flags_q <= '0;
        end else if (phase == PH_WRITE) begin
            if ((op_q == OP_ADJ) || !dest_q) w_q <= res_q;
            flags_q <= nfl_q;
        end
    end

    assign file_we  = (phase == PH_WRITE) && (op_q == OP_DEC) && dest_q;
    assign file_out = res_q;
    assign phase_o  = phase;
    assign w_out    = w_q;
    assign c_o      = flags_q.c;
    assign dc_o     = flags_q.dc;
    assign n_o      = flags_q.n;
    assign ov_o     = flags_q.ov;
    assign z_o      = flags_q.z;

    // R7
    fwe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        file_we |-> (phase_o == PH_WRITE));

    // R3
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_WRITE) |=> $stable(w_out));

    // R6
    adj_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && op_q == OP_ADJ) |=> $stable({dc_o, n_o, ov_o, z_o}));

    // R9
    dec_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && op_q == OP_DEC && !dest_q)
            |=> (z_o == (w_out == '0)) && (n_o == w_out[DATA_W-1]));
endmodule

// File: tb/bcdu_core_tb.sv
module bcdu_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_sel = 1'b0, dest_sel = 1'b0, c_in = 1'b0, dc_in = 1'b0;
    logic [7:0] file_in = 8'h00;
    logic [1:0] phase_o;
    logic [7:0] w_out, file_out;
    logic       file_we, c_o, dc_o, n_o, ov_o, z_o;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    bcdu_core u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .dest_sel(dest_sel),
        .file_in(file_in), .c_in(c_in), .dc_in(dc_in), .phase_o(phase_o),
        .w_out(w_out), .file_out(file_out), .file_we(file_we),
        .c_o(c_o), .dc_o(dc_o), .n_o(n_o), .ov_o(ov_o), .z_o(z_o)
    );

    // {op, dest, f[7:0], cin, dcin, expW[7:0], expWe, expFile[7:0], expFlags{C,DC,N,OV,Z}}
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {1'b1,1'b0,8'hA6,1'b0,1'b0, 8'hA5,1'b0,8'h00,5'b11100}, // R7 load W
        {1'b0,1'b0,8'h00,1'b0,1'b0, 8'h05,1'b0,8'h00,5'b11100}, // R5 A5 -> 05
        {1'b1,1'b0,8'hCF,1'b0,1'b0, 8'hCE,1'b0,8'h00,5'b11100},
        {1'b0,1'b1,8'hFF,1'b0,1'b0, 8'h34,1'b0,8'h00,5'b11100}, // R4 R6 CE -> 34, file/dest ignored
        {1'b1,1'b1,8'h01,1'b0,1'b0, 8'h34,1'b1,8'h00,5'b11001}, // R9 zero
        {1'b1,1'b1,8'h80,1'b0,1'b0, 8'h34,1'b1,8'h7F,5'b10010}, // R9 overflow
        {1'b1,1'b1,8'h00,1'b0,1'b0, 8'h34,1'b1,8'hFF,5'b00100}, // R8 full borrow
        {1'b0,1'b0,8'h00,1'b0,1'b1, 8'h3A,1'b0,8'h00,5'b00100}, // R4 forced by DC
        {1'b1,1'b0,8'h13,1'b0,1'b0, 8'h12,1'b0,8'h00,5'b11000},
        {1'b0,1'b0,8'h00,1'b1,1'b0, 8'h72,1'b0,8'h00,5'b11000}, // R5 R6 forced by C
        {1'b1,1'b0,8'h9A,1'b0,1'b0, 8'h99,1'b0,8'h00,5'b11100},
        {1'b0,1'b0,8'h00,1'b0,1'b0, 8'h99,1'b0,8'h00,5'b01100}, // R6 valid BCD passes, C cleared
        {1'b1,1'b0,8'h9B,1'b0,1'b0, 8'h9A,1'b0,8'h00,5'b11100},
        {1'b0,1'b0,8'h00,1'b0,1'b0, 8'h00,1'b0,8'h00,5'b11100}  // R5 low carry pushes high
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Run one instruction from a decode-phase negedge; leaves at the next decode-phase negedge.
    task automatic run(input logic [33:0] v, input int idx);
        op_sel = v[33]; dest_sel = v[32]; file_in = v[31:24];
        c_in = v[23]; dc_in = v[22];
        @(negedge clk);
        chk("R1 phase read", 32'(phase_o), 32'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R1 phase write", 32'(phase_o), 32'd3);
        chk($sformatf("R7 we row %0d", idx), 32'(file_we), 32'(v[13]));
        if (v[13]) chk($sformatf("R7 file_out row %0d", idx), 32'(file_out), 32'(v[12:5]));
        @(negedge clk);
        chk("R1 phase wrap", 32'(phase_o), 32'd0);
        chk($sformatf("R3 R4 R5 R7 W row %0d", idx), 32'(w_out), 32'(v[21:14]));
        chk($sformatf("R6 R8 R9 flags row %0d", idx),
            32'({c_o, dc_o, n_o, ov_o, z_o}), 32'(v[4:0]));
        chk("R7 we low after write", 32'(file_we), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset W", 32'(w_out), 32'd0);
        chk("R2 reset flags", 32'({c_o, dc_o, n_o, ov_o, z_o}), 32'd0);
        chk("R2 reset file", 32'({file_we, file_out}), 32'd0);
        chk("R1 reset phase", 32'(phase_o), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run(VEC[i], i);

        // Reset in the middle of a decrement to file.
        op_sel = 1'b1; dest_sel = 1'b1; file_in = 8'h05;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 mid reset phase", 32'(phase_o), 32'd0);
        chk("R2 mid reset W", 32'(w_out), 32'd0);
        chk("R2 mid reset flags", 32'({c_o, dc_o, n_o, ov_o, z_o}), 32'd0);
        chk("R2 mid reset file", 32'({file_we, file_out}), 32'd0);
        rst_n = 1'b1;
        run({1'b1,1'b0,8'h01,1'b0,1'b0, 8'h00,1'b0,8'h00,5'b11001}, 99);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule